// File: doc/BRIEF.md
# Configurable SPI-Format Serial Master

This block is a master-side serial shift engine. It moves one frame at a time between a parallel word interface and a four-wire SPI-style link made of a serial clock, a data output, a data input and an active-low select. A frame carries 4 to 16 bits and is shifted most significant bit first. The idle level of the serial clock and the edge on which data is captured can each be programmed. An internal loopback path lets the engine receive its own transmit stream without touching the data input pin.

The bit rate comes from two dividers in cascade. An even prescaler feeds a rate counter, so one half bit period lasts `(P/2)*(rate_div+1)` system clocks. P is the prescale value with its lowest bit cleared, and any value below 2 is treated as 2. The frame length, phase, loopback choice and both divider settings are captured when a word is accepted, so they stay fixed for the whole frame. The clock idle level follows `cpol` whenever the engine is idle.

Both parallel sides use valid/ready. The engine accepts a transmit word only when it is enabled, idle, and holds no undelivered received word. A received word is held on `rx_data`, with `rx_valid` high, until the consumer raises `rx_ready`. A slow consumer therefore stalls the transmit side rather than losing data. Each frame is a complete exchange: one accepted transmit word produces exactly one received word.

Top module: `spi_frame_master`

## Requirements
- R1: After reset `sel_n` is high, `busy` and `rx_valid` are low, and from the first clock after reset `sck` rests at the level of `cpol`.
- R2: The frame length is `frame_size+1` bits when `frame_size` is 3 to 15, and 4 bits when it is 0 to 2. A frame drives exactly twice that many `sck` transitions, and `mosi` carries the low frame-length bits of `tx_data`, most significant first.
- R3: The received bits are right-justified in `rx_data` in arrival order, and every bit above the frame length reads 0.
- R4: While idle, `sck` rests low when `cpol`=0 and high when `cpol`=1, and it returns to that level after the last transition of a frame.
- R5: With `cpha`=0, the input is captured on the odd-numbered `sck` transitions (1st, 3rd, ...) and the first data bit is on `mosi` before the first transition. With `cpha`=1, the input is captured on the even-numbered transitions.
- R6: Successive `sck` transitions are H=(P/2)*(`rate_div`+1) system clocks apart. P is `prescale` with bit 0 forced to 0, and P=2 when that result is below 2.
- R7: `sel_n` falls on the clock edge that accepts the word, which is H clocks before the first `sck` transition. It rises H clocks after the last transition.
- R8: With `loopback`=1, the received word equals the transmitted frame bits, whatever is on `miso`.
- R9: `busy` is high from the accepting edge until `sel_n` rises, and is low otherwise.
- R10: While `enable` is low, `tx_ready` is low and no frame starts. A frame already in progress completes.
- R11: A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only when the engine is enabled, idle, and `rx_valid` is low. While `rx_valid` is high and `rx_ready` is low, `rx_valid` and `rx_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Permits new frames to start |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: capture on odd transitions, 1: capture on even transitions |
| loopback | input | 1 | Route the transmit stream to the receive path |
| frame_size | input | 4 | Frame length minus one |
| prescale | input | 8 | First divider stage (even, at least 2) |
| rate_div | input | 8 | Second divider stage, divides by value+1 |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine will accept a word this cycle |
| tx_data | input | 16 | Transmit word, frame bits right-justified |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 16 | Received word, right-justified |
| busy | output | 1 | A frame is in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_n | output | 1 | Active-low select |

## Verification
The hardest state to reach from the ports is a stall. A finished frame's word sits unclaimed on the receive side while a new transmit word is already offered, so the engine has to refuse the new word without dropping or altering the held one. The stimulus lowers `rx_ready` before a frame and offers a second word once that frame ends. It then watches for dozens of cycles that `sel_n` stays high, `tx_ready` stays low and `rx_data` holds its value. Only after that does it release the consumer and let the second frame run. A bench model of a serial target drives `miso` on the edges opposite to the capture edges and records `mosi`. This checks every pairing of `cpol` and `cpha` against the required transition timing, including odd and zero prescale values.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } phase_e;
endpackage

// File: rtl/spi_fm_baud.sv
module spi_fm_baud #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] pre_half,
  input  logic [CNT_W-1:0] rate,
  output logic             half_tick
);
  logic [CNT_W-1:0] pcnt;
  logic [CNT_W-1:0] rcnt;
  logic             ptick;

  assign ptick     = run && (pcnt == pre_half - 1'b1);
  assign half_tick = ptick && (rcnt == rate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      rcnt <= '0;
    end else if (!run) begin
      pcnt <= '0;
      rcnt <= '0;
    end else begin
      pcnt <= ptick ? '0 : pcnt + 1'b1;
      if (half_tick)  rcnt <= '0;
      else if (ptick) rcnt <= rcnt + 1'b1;
    end
  end

  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pcnt < pre_half)); // R6
  AST_RATE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rcnt <= rate)); // R6
endmodule

// File: rtl/spi_fm_shifter.sv
module spi_fm_shifter
  import spi_fm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] load_word,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              cpha,
  input  logic              cpol,
  input  logic              loopback,
  input  logic              miso,
  input  logic              half_tick,
  output logic              run,
  output logic              sck,
  output logic              mosi,
  output logic              sel_n,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int EDGE_W = $clog2(2 * DATA_W + 1);

  phase_e            state;
  logic [DATA_W-1:0] txs;
  logic [DATA_W-1:0] rxs;
  logic [EDGE_W-1:0] edge_cnt;
  logic [EDGE_W-1:0] edge_next;
  logic [EDGE_W-1:0] total;
  logic              do_edge;
  logic              take;
  logic              launch;
  logic              in_bit;

  assign total     = EDGE_W'(2 * (int'(len_m1) + 1));
  assign edge_next = edge_cnt + 1'b1;
  assign do_edge   = half_tick && (state == ST_LEAD || state == ST_SHIFT);
  assign take      = cpha ? !edge_next[0] : edge_next[0];
  assign launch    = cpha ? (edge_next[0] && edge_next != EDGE_W'(1))
                          : (!edge_next[0] && edge_next != total);
  assign mosi      = txs[DATA_W-1];
  assign in_bit    = loopback ? mosi : miso;
  assign run       = (state != ST_IDLE);
  assign done      = (state == ST_TRAIL) && half_tick;
  assign rx_word   = rxs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sck      <= 1'b0;
      sel_n    <= 1'b1;
      txs      <= '0;
      rxs      <= '0;
      edge_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          sck <= cpol;
          if (start) begin
            state    <= ST_LEAD;
            sel_n    <= 1'b0;
            txs      <= load_word;
            rxs      <= '0;
            edge_cnt <= '0;
          end
        end
        ST_LEAD, ST_SHIFT: begin
          if (do_edge) begin
            sck      <= ~sck;
            edge_cnt <= edge_next;
            if (take)   rxs <= {rxs[DATA_W-2:0], in_bit};
            if (launch) txs <= {txs[DATA_W-2:0], 1'b0};
            state <= (edge_next == total) ? ST_TRAIL : ST_SHIFT;
          end
        end
        default: begin
          if (half_tick) begin
            state <= ST_IDLE;
            sel_n <= 1'b1;
          end
        end
      endcase
    end
  end

  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (edge_cnt <= total)); // R2
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> sel_n); // R9
  AST_TRAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRAIL && $past(state) == ST_TRAIL) |-> $stable(sck)); // R4
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 8,
  parameter int MIN_BITS = 4,
  parameter int LEN_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              loopback,
  input  logic [LEN_W-1:0]  frame_size,
  input  logic [CNT_W-1:0]  prescale,
  input  logic [CNT_W-1:0]  rate_div,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              sel_n
);
  localparam logic [LEN_W-1:0] MIN_M1 = LEN_W'(MIN_BITS - 1);
  localparam logic [LEN_W-1:0] TOP_M1 = LEN_W'(DATA_W - 1);

  logic [LEN_W-1:0]  size_eff;
  logic [CNT_W-1:0]  pre_sh;
  logic [CNT_W-1:0]  pre_half_c;
  logic [DATA_W-1:0] aligned;
  logic              accept;
  logic              run;
  logic              half_tick;
  logic              done;
  logic [DATA_W-1:0] rx_word;

  logic [LEN_W-1:0]  len_q;
  logic              cpha_q;
  logic              loop_q;
  logic [CNT_W-1:0]  pre_half_q;
  logic [CNT_W-1:0]  rate_q;

  assign size_eff   = (frame_size < MIN_M1) ? MIN_M1 : frame_size;
  assign pre_sh     = {1'b0, prescale[CNT_W-1:1]};
  assign pre_half_c = (pre_sh == '0) ? CNT_W'(1) : pre_sh;
  assign aligned    = tx_data << (TOP_M1 - size_eff);
  assign tx_ready   = enable && !run && !rx_valid;
  assign accept     = tx_valid && tx_ready;
  assign busy       = run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q      <= MIN_M1;
      cpha_q     <= 1'b0;
      loop_q     <= 1'b0;
      pre_half_q <= CNT_W'(1);
      rate_q     <= '0;
    end else if (accept) begin
      len_q      <= size_eff;
      cpha_q     <= cpha;
      loop_q     <= loopback;
      pre_half_q <= pre_half_c;
      rate_q     <= rate_div;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (done) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_word;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  spi_fm_baud #(.CNT_W(CNT_W)) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .pre_half  (pre_half_q),
    .rate      (rate_q),
    .half_tick (half_tick)
  );

  spi_fm_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .load_word (aligned),
    .len_m1    (len_q),
    .cpha      (cpha_q),
    .cpol      (cpol),
    .loopback  (loop_q),
    .miso      (miso),
    .half_tick (half_tick),
    .run       (run),
    .sck       (sck),
    .mosi      (mosi),
    .sel_n     (sel_n),
    .done      (done),
    .rx_word   (rx_word)
  );

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R11
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (busy && !sel_n)); // R9
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !busy) |=> !busy); // R10
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!busy && sel_n && !rx_valid)); // R11
endmodule

// File: tb/spi_frame_master_test.sv
`timescale 1ns/1ps
module spi_frame_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        cpol = 1'b0;
  logic        cpha = 1'b0;
  logic        loopback = 1'b0;
  logic [3:0]  frame_size = 4'd7;
  logic [7:0]  prescale = 8'd2;
  logic [7:0]  rate_div = 8'd0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] tx_data = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [15:0] rx_data;
  logic        busy;
  logic        sck;
  logic        mosi;
  logic        miso;
  logic        sel_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_frame_master uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .cpha(cpha),
    .loopback(loopback), .frame_size(frame_size), .prescale(prescale),
    .rate_div(rate_div), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .busy(busy), .sck(sck), .mosi(mosi), .miso(miso),
    .sel_n(sel_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  int q_rx[$];
  int q_tx[$];
  int q_n[$];
  int q_h[$];

  // serial target model
  logic [15:0] slv_word = '0;
  logic        miso_r = 1'b0;
  int          cur_n = 8;
  int          idx;
  int          edges;
  logic [15:0] mosi_w;
  realtime     t_fall, t_first, t_last, t_rise;
  int          sel_falls = 0;
  int          busy_bad = 0;
  assign miso = miso_r;

  always @(negedge sel_n) begin
    sel_falls++;
    t_fall = $realtime;
    edges = 0;
    mosi_w = '0;
    idx = cur_n - 1;
    if (!cpha) miso_r = slv_word[idx];
  end

  always @(posedge sel_n) t_rise = $realtime;

  always @(sck) begin
    if (!sel_n) begin
      edges++;
      if (edges == 1) t_first = $realtime;
      t_last = $realtime;
      if (!cpha) begin
        if (sck != cpol) mosi_w = {mosi_w[14:0], mosi};
        else begin
          idx--;
          if (idx >= 0) miso_r = slv_word[idx];
        end
      end else begin
        if (sck != cpol) begin
          if (idx >= 0) miso_r = slv_word[idx];
          idx--;
        end else mosi_w = {mosi_w[14:0], mosi};
      end
    end
  end

  // R9: busy must cover the whole select window
  always @(negedge clk) if (rst_n && ((!sel_n) != busy)) busy_bad++;

  // monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (q_rx.size() == 0) check(0, "R11 unexpected word", rx_data, 0);
      else begin
        int erx, etx, en, eh, lead, trail;
        erx = q_rx.pop_front(); etx = q_tx.pop_front();
        en = q_n.pop_front(); eh = q_h.pop_front();
        lead  = int'((t_first - t_fall) / 5.0);
        trail = int'((t_rise - t_last) / 5.0);
        check(rx_data == 16'(erx), "R3 R5 R8 rx word", rx_data, erx);
        check(mosi_w == 16'(etx), "R2 R5 mosi bits", mosi_w, etx);
        check(edges == 2 * en, "R2 sck transitions", edges, 2 * en);
        check(lead == eh, "R6 R7 lead half period", lead, eh);
        check(trail == eh, "R7 trail half period", trail, eh);
        check(sck == cpol, "R4 sck rest after frame", sck, cpol);
      end
    end
  end

  task automatic send(input logic [15:0] w, input logic [15:0] sw);
    int n, p, h;
    logic [15:0] m;
    n = (frame_size < 3) ? 4 : int'(frame_size) + 1;
    p = int'(prescale) & ~1;
    if (p < 2) p = 2;
    h = (p / 2) * (int'(rate_div) + 1);
    m = 16'((32'h1 << n) - 1);
    cur_n = n;
    slv_word = sw;
    q_tx.push_back(int'(w & m));
    q_rx.push_back(loopback ? int'(w & m) : int'(sw & m));
    q_n.push_back(n);
    q_h.push_back(h);
    @(negedge clk);
    tx_data = w;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_rx.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg(input int p, input int r, input bit pol, input bit pha,
                     input bit lb, input int sz);
    prescale = 8'(p); rate_div = 8'(r); cpol = pol; cpha = pha;
    loopback = lb; frame_size = 4'(sz);
    repeat (3) @(negedge clk);
    check(sck == pol, "R4 idle sck level", sck, pol);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sel_n == 1'b1, "R1 select idle", sel_n, 1);
    check(busy == 1'b0, "R1 busy low", busy, 0);
    check(rx_valid == 1'b0, "R1 rx_valid low", rx_valid, 0);
    check(sck == 1'b0, "R1 sck at cpol", sck, 0);
    check(tx_ready == 1'b1, "R11 ready when idle", tx_ready, 1);

    cfg(2, 0, 0, 0, 0, 7);  send(16'h00A5, 16'h003C); drain();
    cfg(4, 1, 0, 1, 0, 7);  send(16'h005A, 16'h00C3); drain();
    cfg(6, 0, 1, 0, 0, 15); send(16'hBEEF, 16'h1234); drain();
    cfg(2, 2, 1, 1, 0, 3);  send(16'hFFF9, 16'hFFF6); drain();  // R3 upper bits
    cfg(3, 1, 0, 0, 0, 11); send(16'h0ABC, 16'h05A5); drain();  // R6 odd prescale
    cfg(0, 0, 1, 1, 0, 6);  send(16'h0055, 16'h002A); drain();  // R6 zero prescale
    cfg(4, 0, 0, 0, 1, 9);  send(16'h02C3, 16'h013C); drain();  // R8 loopback
    cfg(2, 1, 1, 0, 1, 15); send(16'h8001, 16'h7FFE); drain();  // R8 loopback
    cfg(2, 0, 0, 1, 0, 1);  send(16'hFFFA, 16'h0005); drain();  // R2 short size

    // R10: disabled engine refuses to start
    begin
      int f0;
      f0 = sel_falls;
      enable = 1'b0;
      tx_data = 16'h0033;
      tx_valid = 1'b1;
      repeat (40) begin
        @(negedge clk);
        if (tx_ready) check(0, "R10 ready while disabled", tx_ready, 0);
      end
      check(sel_falls == f0, "R10 no frame while disabled", sel_falls - f0, 0);
      check(busy == 1'b0, "R10 busy stays low", busy, 0);
      tx_valid = 1'b0;
      enable = 1'b1;
    end

    // R11: receive back-pressure stalls transmit side
    begin
      int f0;
      logic [15:0] held;
      cfg(2, 0, 0, 0, 0, 7);
      rx_ready = 1'b0;
      send(16'h0081, 16'h0066);
      while (!rx_valid) @(negedge clk);
      held = rx_data;
      f0 = sel_falls;
      tx_data = 16'h0042;
      tx_valid = 1'b1;
      repeat (50) @(negedge clk);
      check(tx_ready == 1'b0, "R11 ready low with word pending", tx_ready, 0);
      check(sel_falls == f0, "R11 no start while stalled", sel_falls - f0, 0);
      check(rx_valid && rx_data == held, "R11 word held", rx_data, held);
      tx_valid = 1'b0;
      rx_ready = 1'b1;
      drain();
      send(16'h0042, 16'h0099); drain();
    end

    check(busy_bad == 0, "R9 busy matches select window", busy_bad, 0);
    check(q_rx.size() == 0, "R11 all words delivered", q_rx.size(), 0);
    finish_run();
  end
endmodule